// File: doc/BRIEF.md
# Dual Potentiometer Register Command Executor

This block sits behind a two-wire serial slave front end and carries out the register commands for a pair of digitally controlled potentiometers. Each pot owns a 6-bit wiper counter register (WCR), which sets the tap the wiper uses, and four 6-bit data registers that model nonvolatile cells. The front end hands over whole bytes as one-cycle strobes: the instruction byte, any following data byte, single wiper steps during a step session, and the stop condition. The executor answers with acknowledge or reject pulses, read data and a busy flag. The front end uses the busy flag to refuse its address while a nonvolatile write is in progress.

The instruction byte holds a 4-bit opcode in bits 7..4 and a zero bit in bit 3. Bit 2 selects the pot and bits 1..0 select the data register. Some commands finish with the instruction byte. Others wait for one data byte, or open a session of wiper steps that lasts until the stop condition. A data register write, whether from the host or copied from a WCR, is only staged when it is received. It is committed after the stop condition, at the end of a programmable busy period. Copies from a data register into the WCR take effect at once.

Top module: `dpot_cmd_exec`

## Requirements
- R1: After reset, data register r of pot p holds (INIT_SEED + 11*r + 23*p) mod 64. Each WCR holds the reset value of data register 0 of its pot. busy is low.
- R2: An instruction byte is acknowledged when bits 7..4 are one of 0001, 0010, 1000, 1001, 1010, 1011, 1100, 1101 or 1110, bit 3 is 0 and busy is low. Acknowledge is a `cmd_ack` pulse in the cycle after `cmd_valid`. Any other byte gives a `cmd_nak` pulse in that cycle instead.
- R3: Opcode 1001 reads the WCR and opcode 1011 reads data register bits 1..0 of pot bit 2. The value is returned on `rd_data`, zero-extended to 8 bits, with `rd_valid` in the same cycle as `cmd_ack`.
- R4: After opcode 1010, the next data byte loads bits 5..0 into the selected WCR. Bits 7..6 are ignored. `data_ack` pulses and the wiper output changes in the cycle after `data_valid`.
- R5: After opcode 1100, the next data byte is staged for the selected data register, which keeps its old value until a stop. The stop raises busy for exactly BUSY_CYCLES cycles, and the register holds the new value once busy falls.
- R6: Opcode 1101 loads the selected pot's WCR from the selected data register in the cycle after the instruction. The other pot is unchanged.
- R7: Opcode 1110 captures the selected pot's WCR at the instruction and commits it to the selected data register through the stop and busy sequence of R5.
- R8: Opcode 0001 loads both WCRs from their own data register r. Opcode 1000 commits both WCRs into their own data register r through the sequence of R5.
- R9: After opcode 0010, each `step_valid` moves the selected wiper one count up when `step_up` is 1 and down when it is 0. The wiper saturates at 63 and 0, the other pot is unchanged, and the session ends at a stop.
- R10: While busy is high every instruction byte is rejected. Data bytes and steps change nothing.
- R11: A data byte that arrives when no write command is waiting changes no register and produces no `data_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction byte strobe |
| cmd_byte | input | 8 | Instruction byte |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte from the host |
| step_valid | input | 1 | One wiper step in a step session |
| step_up | input | 1 | Step direction, 1 toward the high terminal |
| stop_evt | input | 1 | Stop condition seen on the bus |
| cmd_ack | output | 1 | Instruction accepted |
| cmd_nak | output | 1 | Instruction rejected |
| data_ack | output | 1 | Data byte accepted |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 8 | Read data to the host |
| busy | output | 1 | Nonvolatile write in progress |
| wiper0 | output | 6 | Tap selected on pot 0 |
| wiper1 | output | 6 | Tap selected on pot 1 |

## Verification
A corrupted WCR shows on the wiper port in the cycle after the command that wrote it. A corrupted data register stays hidden until a read or a copy into the WCR, so every nonvolatile write is followed by read-back of both pots. A wrong sequencer state shows one cycle after the next byte, as a missing or extra acknowledge or data pulse. A wrong write timer shows as a busy run whose length differs from BUSY_CYCLES, or as a register that still reads the old value once busy has fallen.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int WIPER_W   = 6;
  localparam int NUM_POTS  = 2;
  localparam int NUM_REGS  = 4;

  typedef enum logic [3:0] {
    OP_GLB_DR2WCR = 4'b0001,
    OP_STEP       = 4'b0010,
    OP_GLB_WCR2DR = 4'b1000,
    OP_RD_WCR     = 4'b1001,
    OP_WR_WCR     = 4'b1010,
    OP_RD_DR      = 4'b1011,
    OP_WR_DR      = 4'b1100,
    OP_DR2WCR     = 4'b1101,
    OP_WCR2DR     = 4'b1110
  } op_e;

  typedef struct packed {
    logic       legal;
    op_e        op;
    logic       pot;
    logic [1:0] rsel;
  } cmd_t;

  // one saturating step of a wiper counter
  function automatic logic [WIPER_W-1:0] step_val(input logic [WIPER_W-1:0] v,
                                                  input logic up);
    if (up) return (v == '1) ? v : v + 1'b1;
    else    return (v == '0) ? v : v - 1'b1;
  endfunction

  // power-on content of a modelled nonvolatile cell
  function automatic logic [WIPER_W-1:0] reset_val(input int pot, input int idx,
                                                   input logic [WIPER_W-1:0] seed);
    int s;
    s = int'(seed) + 11 * idx + 23 * pot;
    return WIPER_W'(s % (1 << WIPER_W));
  endfunction
endpackage

// File: rtl/dpot_decode.sv
module dpot_decode
  import dpot_pkg::*;
(
  input  logic [7:0] instr,
  output cmd_t       cmd
);
  always_comb begin
    cmd.op   = op_e'(instr[7:4]);
    cmd.pot  = instr[2];
    cmd.rsel = instr[1:0];
    case (instr[7:4])
      4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
      4'b1011, 4'b1100, 4'b1101, 4'b1110: cmd.legal = ~instr[3];
      default:                            cmd.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dpot_bank.sv
module dpot_bank
  import dpot_pkg::*;
#(
  parameter int                 NREG   = NUM_REGS,
  parameter int                 POT_ID = 0,
  parameter logic [WIPER_W-1:0] SEED   = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wcr_we,
  input  logic [WIPER_W-1:0]        wcr_wd,
  input  logic                      dr_we,
  input  logic [$clog2(NREG)-1:0]   dr_idx,
  input  logic [WIPER_W-1:0]        dr_wd,
  output logic [WIPER_W-1:0]        wcr_q,
  output logic [NREG*WIPER_W-1:0]   dr_flat
);
  localparam int IW = $clog2(NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcr_q <= reset_val(POT_ID, 0, SEED);
    else if (wcr_we) wcr_q <= wcr_wd;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    localparam logic [IW-1:0] SLOT = IW'(i);
    logic [WIPER_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cell_q <= reset_val(POT_ID, i, SEED);
      else if (dr_we && dr_idx == SLOT) cell_q <= dr_wd;
    end
    assign dr_flat[i*WIPER_W +: WIPER_W] = cell_q;
  end
endmodule

// File: rtl/dpot_nvtimer.sv
module dpot_nvtimer #(
  parameter int BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/dpot_cmd_exec.sv
module dpot_cmd_exec
  import dpot_pkg::*;
#(
  parameter int                 BUSY_CYCLES = 40,
  parameter logic [WIPER_W-1:0] INIT_SEED   = WIPER_W'(9)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       data_valid,
  input  logic [7:0] data_byte,
  input  logic       step_valid,
  input  logic       step_up,
  input  logic       stop_evt,
  output logic       cmd_ack,
  output logic       cmd_nak,
  output logic       data_ack,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic [5:0] wiper0,
  output logic [5:0] wiper1
);
  localparam int IW = $clog2(NUM_REGS);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_WCR, ST_WAIT_DR, ST_STEP} st_e;

  st_e                st_q, st_n;
  logic               sel_pot_q;
  logic [IW-1:0]      sel_reg_q;
  cmd_t               cmd;

  logic [WIPER_W-1:0]          wcr_q   [NUM_POTS];
  logic [NUM_REGS*WIPER_W-1:0] dr_flat [NUM_POTS];
  logic [WIPER_W-1:0]          dr_pick [NUM_POTS];
  logic [NUM_POTS-1:0]         wcr_we;
  logic [WIPER_W-1:0]          wcr_wd  [NUM_POTS];
  logic [NUM_POTS-1:0]         dr_we;

  logic                pend_valid_q, pend_set;
  logic [NUM_POTS-1:0] pend_mask_q, pend_mask_n;
  logic [IW-1:0]       pend_idx_q, pend_idx_n;
  logic [WIPER_W-1:0]  pend_val_q [NUM_POTS];
  logic [WIPER_W-1:0]  pend_val_n [NUM_POTS];

  // named internal events
  logic cmd_go, cmd_bad, data_go, step_go, nv_start, nv_done, rd_go;
  logic [WIPER_W-1:0] rd_val;
  logic [1:0] unused_data_hi;

  assign unused_data_hi = data_byte[7:WIPER_W];

  dpot_decode u_dec (.instr(cmd_byte), .cmd(cmd));

  assign cmd_go   = cmd_valid && !stop_evt && cmd.legal && !busy;
  assign cmd_bad  = cmd_valid && !stop_evt && !cmd_go;
  assign data_go  = data_valid && !stop_evt && !cmd_valid &&
                    (st_q == ST_WAIT_WCR || st_q == ST_WAIT_DR);
  assign step_go  = step_valid && !stop_evt && !cmd_valid && !data_valid &&
                    (st_q == ST_STEP);
  assign nv_start = stop_evt && pend_valid_q && !busy;
  assign rd_go    = cmd_go && (cmd.op == OP_RD_WCR || cmd.op == OP_RD_DR);

  always_comb begin
    for (int p = 0; p < NUM_POTS; p++)
      dr_pick[p] = dr_flat[p][cmd.rsel*WIPER_W +: WIPER_W];
  end

  assign rd_val = (cmd.op == OP_RD_WCR) ? wcr_q[cmd.pot] : dr_pick[cmd.pot];

  // volatile wiper updates
  always_comb begin
    for (int p = 0; p < NUM_POTS; p++) begin
      wcr_we[p] = 1'b0;
      wcr_wd[p] = wcr_q[p];
      if (cmd_go && ((cmd.op == OP_DR2WCR && cmd.pot == 1'(p)) ||
                     cmd.op == OP_GLB_DR2WCR)) begin
        wcr_we[p] = 1'b1;
        wcr_wd[p] = dr_pick[p];
      end
      if (data_go && st_q == ST_WAIT_WCR && sel_pot_q == 1'(p)) begin
        wcr_we[p] = 1'b1;
        wcr_wd[p] = data_byte[WIPER_W-1:0];
      end
      if (step_go && sel_pot_q == 1'(p)) begin
        wcr_we[p] = 1'b1;
        wcr_wd[p] = step_val(wcr_q[p], step_up);
      end
    end
  end

  // staging of nonvolatile writes
  always_comb begin
    pend_set    = 1'b0;
    pend_mask_n = pend_mask_q;
    pend_idx_n  = pend_idx_q;
    for (int p = 0; p < NUM_POTS; p++) pend_val_n[p] = pend_val_q[p];
    if (cmd_go && cmd.op == OP_WCR2DR) begin
      pend_set               = 1'b1;
      pend_mask_n            = '0;
      pend_mask_n[cmd.pot]   = 1'b1;
      pend_idx_n             = cmd.rsel;
      pend_val_n[cmd.pot]    = wcr_q[cmd.pot];
    end else if (cmd_go && cmd.op == OP_GLB_WCR2DR) begin
      pend_set    = 1'b1;
      pend_mask_n = '1;
      pend_idx_n  = cmd.rsel;
      for (int p = 0; p < NUM_POTS; p++) pend_val_n[p] = wcr_q[p];
    end else if (data_go && st_q == ST_WAIT_DR) begin
      pend_set               = 1'b1;
      pend_mask_n            = '0;
      pend_mask_n[sel_pot_q] = 1'b1;
      pend_idx_n             = sel_reg_q;
      pend_val_n[sel_pot_q]  = data_byte[WIPER_W-1:0];
    end
  end

  always_comb begin
    st_n = st_q;
    if (stop_evt) st_n = ST_IDLE;
    else if (cmd_valid) begin
      st_n = ST_IDLE;
      if (cmd_go) begin
        case (cmd.op)
          OP_WR_WCR: st_n = ST_WAIT_WCR;
          OP_WR_DR:  st_n = ST_WAIT_DR;
          OP_STEP:   st_n = ST_STEP;
          default:   st_n = ST_IDLE;
        endcase
      end
    end else if (data_go) st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      sel_pot_q    <= 1'b0;
      sel_reg_q    <= '0;
      pend_valid_q <= 1'b0;
      pend_mask_q  <= '0;
      pend_idx_q   <= '0;
      for (int p = 0; p < NUM_POTS; p++) pend_val_q[p] <= '0;
      cmd_ack      <= 1'b0;
      cmd_nak      <= 1'b0;
      data_ack     <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
    end else begin
      st_q     <= st_n;
      cmd_ack  <= cmd_go;
      cmd_nak  <= cmd_bad;
      data_ack <= data_go;
      rd_valid <= rd_go;
      if (rd_go) rd_data <= {{(8-WIPER_W){1'b0}}, rd_val};
      if (cmd_go) begin
        sel_pot_q <= cmd.pot;
        sel_reg_q <= cmd.rsel;
      end
      if (pend_set) begin
        pend_valid_q <= 1'b1;
        pend_mask_q  <= pend_mask_n;
        pend_idx_q   <= pend_idx_n;
        for (int p = 0; p < NUM_POTS; p++) pend_val_q[p] <= pend_val_n[p];
      end else if (nv_start) begin
        pend_valid_q <= 1'b0;
      end
    end
  end

  dpot_nvtimer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(busy), .done(nv_done)
  );

  assign dr_we = nv_done ? pend_mask_q : '0;

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    dpot_bank #(.NREG(NUM_REGS), .POT_ID(p), .SEED(INIT_SEED)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wcr_we(wcr_we[p]), .wcr_wd(wcr_wd[p]),
      .dr_we(dr_we[p]), .dr_idx(pend_idx_q), .dr_wd(pend_val_q[p]),
      .wcr_q(wcr_q[p]), .dr_flat(dr_flat[p])
    );
  end

  assign wiper0 = wcr_q[0];
  assign wiper1 = wcr_q[1];
endmodule

// File: rtl/dpot_checker.sv
module dpot_checker #(
  parameter int BUSY_CYCLES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ack,
  input logic       cmd_nak,
  input logic       data_valid,
  input logic       data_ack,
  input logic       rd_valid,
  input logic       busy,
  input logic       stop_evt,
  input logic       step_go,
  input logic [5:0] wiper0,
  input logic [5:0] wiper1
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  p_ack_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack && cmd_nak));

  p_reply_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack || cmd_nak) |-> $past(cmd_valid));

  p_read_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cmd_ack);

  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BUSY_CYCLES);

  p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |=> ((wiper0 == $past(wiper0) || wiper0 == $past(wiper0) + 6'd1 ||
                  wiper0 == $past(wiper0) - 6'd1) &&
                 (wiper1 == $past(wiper1) || wiper1 == $past(wiper1) + 6'd1 ||
                  wiper1 == $past(wiper1) - 6'd1)));

  p_busy_nak_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !stop_evt) |=> (cmd_nak && !cmd_ack));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wiper0) && $stable(wiper1)));

  p_data_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_ack |-> $past(data_valid));
endmodule

bind dpot_cmd_exec dpot_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ack(cmd_ack),
  .cmd_nak(cmd_nak), .data_valid(data_valid), .data_ack(data_ack),
  .rd_valid(rd_valid), .busy(busy), .stop_evt(stop_evt), .step_go(step_go),
  .wiper0(wiper0), .wiper1(wiper1)
);

// File: tb/dpot_cmd_exec_tb_top.sv
`timescale 1ns/1ps
module dpot_cmd_exec_tb_top;
  localparam int BUSY = 12;
  localparam int SEED = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, data_valid = 1'b0, step_valid = 1'b0;
  logic       step_up = 1'b0, stop_evt = 1'b0;
  logic [7:0] cmd_byte = '0, data_byte = '0;
  logic       cmd_ack, cmd_nak, data_ack, rd_valid, busy;
  logic [7:0] rd_data;
  logic [5:0] wiper0, wiper1;

  dpot_cmd_exec #(.BUSY_CYCLES(BUSY), .INIT_SEED(6'(SEED))) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_byte(data_byte), .step_valid(step_valid),
    .step_up(step_up), .stop_evt(stop_evt), .cmd_ack(cmd_ack),
    .cmd_nak(cmd_nak), .data_ack(data_ack), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .wiper0(wiper0), .wiper1(wiper1)
  );

  typedef struct {
    bit ack; bit nak; bit dack; bit rv; int rd; string req;
  } exp_t;
  exp_t sbq[$];

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  int m_wcr [2];
  int m_dr  [2][4];
  int m_st = 0, m_pot = 0, m_reg = 0;
  bit m_pend = 0, m_busy = 0;
  bit m_pmask [2];
  int m_pidx = 0;
  int m_pval [2];

  function automatic int init_val(int p, int r);
    return (SEED + 11 * r + 23 * p) % 64;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every response strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (cmd_ack || cmd_nak || data_ack || rd_valid)) begin
      if (sbq.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11 unexpected response ack=%0d nak=%0d dack=%0d rv=%0d expected=none",
                 cmd_ack, cmd_nak, data_ack, rd_valid);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, "cmd_ack", int'(cmd_ack), int'(e.ack));
        chk(e.req, "cmd_nak", int'(cmd_nak), int'(e.nak));
        chk(e.req, "data_ack", int'(data_ack), int'(e.dack));
        chk(e.req, "rd_valid", int'(rd_valid), int'(e.rv));
        if (e.rv) chk(e.req, "rd_data", int'(rd_data), e.rd);
      end
    end
  end

  task automatic send_cmd(logic [7:0] b, string req);
    int op, p, r;
    bit legal;
    exp_t e;
    op = int'(b[7:4]); p = int'(b[2]); r = int'(b[1:0]);
    legal = !b[3] && !m_busy && (op inside {1, 2, 8, 9, 10, 11, 12, 13, 14});
    e.ack = legal; e.nak = !legal; e.dack = 0; e.rv = 0; e.rd = 0; e.req = req;
    m_st = 0;
    if (legal) begin
      m_pot = p; m_reg = r;
      case (op)
        9:  begin e.rv = 1; e.rd = m_wcr[p]; end
        11: begin e.rv = 1; e.rd = m_dr[p][r]; end
        10: m_st = 1;
        12: m_st = 2;
        2:  m_st = 3;
        13: m_wcr[p] = m_dr[p][r];
        1:  for (int q = 0; q < 2; q++) m_wcr[q] = m_dr[q][r];
        14: begin
              m_pend = 1; m_pidx = r;
              m_pmask[0] = (p == 0); m_pmask[1] = (p == 1);
              m_pval[p] = m_wcr[p];
            end
        8:  begin
              m_pend = 1; m_pidx = r;
              for (int q = 0; q < 2; q++) begin m_pmask[q] = 1; m_pval[q] = m_wcr[q]; end
            end
        default: ;
      endcase
    end
    sbq.push_back(e);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_data(logic [7:0] d, string req);
    exp_t e;
    if (m_st == 1 || m_st == 2) begin
      e.ack = 0; e.nak = 0; e.dack = 1; e.rv = 0; e.rd = 0; e.req = req;
      sbq.push_back(e);
      if (m_st == 1) m_wcr[m_pot] = int'(d) % 64;
      else begin
        m_pend = 1; m_pidx = m_reg;
        m_pmask[0] = (m_pot == 0); m_pmask[1] = (m_pot == 1);
        m_pval[m_pot] = int'(d) % 64;
      end
      m_st = 0;
    end
    @(negedge clk); data_valid = 1'b1; data_byte = d;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic step(bit up);
    if (m_st == 3) begin
      if (up && m_wcr[m_pot] < 63) m_wcr[m_pot]++;
      if (!up && m_wcr[m_pot] > 0) m_wcr[m_pot]--;
    end
    @(negedge clk); step_valid = 1'b1; step_up = up;
    @(negedge clk); step_valid = 1'b0;
  endtask

  realtime t_stop;

  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    m_st = 0;
    t_stop = $realtime;
    if (m_pend && !m_busy) begin m_busy = 1; m_pend = 0; end
  endtask

  task automatic nv_wait(string req);
    int n;
    chk(req, "busy after stop", int'(busy), 1);
    while (busy) @(negedge clk);
    n = int'(($realtime - t_stop) / 5.0);
    chk(req, "busy length", n, BUSY);
    for (int q = 0; q < 2; q++) if (m_pmask[q]) m_dr[q][m_pidx] = m_pval[q];
    m_busy = 0;
  endtask

  task automatic chk_wipers(string req);
    chk(req, "wiper0", int'(wiper0), m_wcr[0]);
    chk(req, "wiper1", int'(wiper1), m_wcr[1]);
  endtask

  task automatic read_all_dr(string req);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++)
        send_cmd(8'hB0 | 8'(p << 2) | 8'(r), req);
    do_stop();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 4; r++) m_dr[p][r] = init_val(p, r);
      m_wcr[p] = m_dr[p][0];
      m_pmask[p] = 0; m_pval[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_wipers("R1");
    chk("R1", "busy", int'(busy), 0);
    read_all_dr("R1");

    // R3 read of both WCRs
    send_cmd(8'h90, "R3");
    send_cmd(8'h94, "R3");
    do_stop();

    // R4 write WCR, upper bits ignored
    send_cmd(8'hA0, "R4");
    send_data(8'hFF, "R4");
    do_stop();
    chk_wipers("R4");
    send_cmd(8'hA0, "R4");
    send_data(8'hC5, "R4");
    do_stop();
    chk_wipers("R4");

    // R11 stray data byte ignored
    send_data(8'h11, "R11");
    chk_wipers("R11");
    send_cmd(8'h90, "R11");
    do_stop();

    // R2 rejected encodings
    send_cmd(8'h00, "R2");
    send_cmd(8'h30, "R2");
    send_cmd(8'hF0, "R2");
    send_cmd(8'h98, "R2");
    send_cmd(8'hA8, "R2");
    send_data(8'h3F, "R2");
    do_stop();
    chk_wipers("R2");

    // R6 data register to WCR, one pot
    send_cmd(8'hD6, "R6");
    do_stop();
    chk_wipers("R6");

    // R5 host write of a data register
    send_cmd(8'hC3, "R5");
    send_data(8'h57, "R5");
    send_cmd(8'hB3, "R5");
    do_stop();
    // R10 busy rejects and ignores
    send_cmd(8'h90, "R10");
    send_data(8'h22, "R10");
    step(1'b1);
    chk_wipers("R10");
    nv_wait("R5");
    read_all_dr("R5");

    // R7 WCR to data register, one pot
    send_cmd(8'hE1, "R7");
    do_stop();
    nv_wait("R7");
    read_all_dr("R7");

    // R8 global data register to WCRs
    send_cmd(8'h13, "R8");
    do_stop();
    chk_wipers("R8");

    // R9 step session with saturation
    send_cmd(8'h24, "R9");
    step(1'b0); step(1'b0); step(1'b0);
    chk_wipers("R9");
    step(1'b1); step(1'b1);
    chk_wipers("R9");
    do_stop();
    step(1'b1);
    chk_wipers("R9");
    send_cmd(8'hA0, "R9");
    send_data(8'h3E, "R9");
    send_cmd(8'h20, "R9");
    step(1'b1); step(1'b1); step(1'b1);
    do_stop();
    chk_wipers("R9");

    // R8 global WCRs to data registers
    send_cmd(8'h82, "R8");
    do_stop();
    nv_wait("R8");
    read_all_dr("R8");

    repeat (4) @(negedge clk);
    chk("R2", "scoreboard left", sbq.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule